// File: doc/BRIEF.md
# H-Bridge Leg Control and Fault Latch

This block turns two command bits into switch enables for the two half-bridge legs of a motor driver. Each leg has three states. It can drive its output high through the high-side switch, drive it low through the low-side switch, or leave it floating with both switches off. Each command bit controls one leg and nothing else.

Two disable paths can override the commands.

- An active-high disable holds all four switches off. The rest of the logic keeps running while it is asserted.
- An active-low enable also holds all four switches off. In addition, its low level requests sleep. Its gating is combinational, so the switches open in the same cycle, before any clock edge.

A short-circuit pulse from the current-limit logic latches the bridge off. So does an over-temperature pulse from the thermal comparator. While a fault is latched, an active-low status flag is asserted. The latch clears only when software toggles one of the two disable inputs.

Each leg is held in a small registered state. Whenever a leg moves between driving high and driving low, it passes through one cycle with both switches off. Analog sensing, the charge pump and the gate drivers sit outside this block.

Top module: `hbridge_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four switch enables are 0, `hiz` is 1 and `fault_n` is 1.
- R2: With no disable active and no fault latched, leg 0 follows `in1` and leg 1 follows `in2`. In each case the enable changes at the next clock edge: a 1 turns on that leg's high-side enable (`hs_en[leg]`) and a 0 turns on its low-side enable (`ls_en[leg]`). Bit 0 of each vector belongs to leg 0.
- R3: The high-side and low-side enables of a leg are never 1 together.
- R4: When a leg changes between driving high and driving low, it spends exactly one cycle with both of its enables at 0 before the new side turns on.
- R5: While `dis_hi` is 1, all four enables are 0 in the same cycle. Fault latching and clearing keep working during this time.
- R6: While `enable` is 0, all four enables are 0. This takes effect combinationally, without waiting for a clock edge.
- R7: `sleep` equals the inverse of `enable` at all times.
- R8: A `short_evt` sampled high at a clock edge latches a fault at that edge. From then on `fault_n` is 0 and all four enables are 0.
- R9: A `hot_evt` sampled high at a clock edge latches a fault in the same way as R8.
- R10: A latched fault clears at a clock edge where `dis_hi` is sampled 0 after being sampled 1 at the edge before, or where `enable` is sampled 1 after being sampled 0. If a fault pulse is present at that same edge, the fault stays latched. Nothing else clears it.
- R11: `hiz` is 1 exactly when all four enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in1 | input | 1 | Level command for leg 0 |
| in2 | input | 1 | Level command for leg 1 |
| dis_hi | input | 1 | Active-high bridge disable |
| enable | input | 1 | Active-low disable that also requests sleep |
| short_evt | input | 1 | Short-circuit report pulse |
| hot_evt | input | 1 | Over-temperature report pulse |
| hs_en | output | 2 | High-side switch enables, one bit per leg |
| ls_en | output | 2 | Low-side switch enables, one bit per leg |
| hiz | output | 1 | All four switches are off |
| sleep | output | 1 | Sleep request |
| fault_n | output | 1 | Active-low latched-fault flag |

## Verification
The hardest situation to reach from the ports is a clear that coincides with a fault report. It needs `dis_hi` to fall, or `enable` to rise, in exactly the cycle in which a fault pulse is applied. The bench builds this case on purpose and expects the latch to stay set.

A long randomized stretch then mixes command flips with rare fault pulses and brief disable toggles. A behavioural model, compared on every cycle, follows the dead-time cycles and the clear edges through this stretch.

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int LEGS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in1,
  input  logic            in2,
  input  logic            dis_hi,
  input  logic            enable,
  input  logic            short_evt,
  input  logic            hot_evt,
  output logic [LEGS-1:0] hs_en,
  output logic [LEGS-1:0] ls_en,
  output logic            hiz,
  output logic            sleep,
  output logic            fault_n
);

  typedef enum logic [1:0] {LV_OFF = 2'd0, LV_HI = 2'd1, LV_LO = 2'd2} lvl_t;

  logic            dis_q, en_q, fault_q;
  logic            clear, block, trip;
  logic [LEGS-1:0] cmd;

  assign cmd   = {in2, in1};
  assign trip  = short_evt | hot_evt;
  assign clear = (dis_q & ~dis_hi) | (~en_q & enable);
  assign block = dis_hi | ~enable | fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= 1'b0;
      en_q    <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      dis_q   <= dis_hi;
      en_q    <= enable;
      fault_q <= trip | (fault_q & ~clear);
    end
  end

  generate
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
      lvl_t cur, tgt;

      always_comb tgt = block ? LV_OFF : (cmd[g] ? LV_HI : LV_LO);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cur <= LV_OFF;
        else if (cur != LV_OFF && tgt != LV_OFF && tgt != cur)
          cur <= LV_OFF;
        else
          cur <= tgt;
      end

      assign hs_en[g] = ~block & (cur == LV_HI);
      assign ls_en[g] = ~block & (cur == LV_LO);

      a_r4_dead_time_hl: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en[g] |=> !ls_en[g]);
      a_r4_dead_time_lh: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en[g] |=> !hs_en[g]);
    end
  endgenerate

  assign hiz     = ~|{hs_en, ls_en};
  assign sleep   = ~enable;
  assign fault_n = ~fault_q;

  a_r3_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en & ls_en) == '0);
  a_r5_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    dis_hi |-> (hs_en == '0 && ls_en == '0));
  a_r6_enable_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (hs_en == '0 && ls_en == '0 && sleep));
  a_r8_short_latches: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |=> !fault_n);
  a_r9_hot_latches: assert property (@(posedge clk) disable iff (!rst_n)
    hot_evt |=> !fault_n);
  a_r8_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> hiz);
  a_r10_clear_by_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> (($past(dis_hi, 2) && !$past(dis_hi)) ||
                        (!$past(enable, 2) && $past(enable))));

endmodule

// File: tb/tb_hbridge_ctrl.sv
module tb_hbridge_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in1 = 0, in2 = 0, dis_hi = 0, enable = 1, short_evt = 0, hot_evt = 0;
  logic [1:0] hs_en, ls_en;
  logic hiz, sleep, fault_n;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  hbridge_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in1(in1), .in2(in2), .dis_hi(dis_hi),
    .enable(enable), .short_evt(short_evt), .hot_evt(hot_evt),
    .hs_en(hs_en), .ls_en(ls_en), .hiz(hiz), .sleep(sleep), .fault_n(fault_n)
  );

  // reference model: level per leg 0=off 1=high 2=low
  int m_lvl[2];
  bit m_fault, m_dis_prev, m_en_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl[0] = 0; m_lvl[1] = 0;
      m_fault = 0; m_dis_prev = 0; m_en_prev = 1;
    end else begin
      bit blocked, cleared;
      int want;
      blocked = dis_hi || !enable || m_fault;
      for (int i = 0; i < 2; i++) begin
        want = blocked ? 0 : (((i == 0) ? in1 : in2) ? 1 : 2);
        if (m_lvl[i] != 0 && want != 0 && want != m_lvl[i]) m_lvl[i] = 0;
        else m_lvl[i] = want;
      end
      cleared = (m_dis_prev && !dis_hi) || (!m_en_prev && enable);
      m_fault = short_evt || hot_evt || (m_fault && !cleared);
      m_dis_prev = dis_hi;
      m_en_prev = enable;
    end
  end

  task automatic check(string tag);
    logic [1:0] ehs, els;
    bit blocked;
    blocked = dis_hi || !enable || m_fault || !rst_n;
    for (int i = 0; i < 2; i++) begin
      ehs[i] = !blocked && m_lvl[i] == 1;
      els[i] = !blocked && m_lvl[i] == 2;
    end
    checks++;
    if (hs_en !== ehs || ls_en !== els) begin
      fails++;
      $display("FAIL %s legs: hs=%b ls=%b expected hs=%b ls=%b", tag, hs_en, ls_en, ehs, els);
    end
    if ((hs_en & ls_en) != 2'b00) begin
      fails++;
      $display("FAIL R3 overlap: hs=%b ls=%b expected no common bit", hs_en, ls_en);
    end
    if (hiz !== (ehs == 0 && els == 0)) begin
      fails++;
      $display("FAIL R11 hiz: %b expected %b", hiz, (ehs == 0 && els == 0));
    end
    if (sleep !== !enable) begin
      fails++;
      $display("FAIL R7 sleep: %b expected %b", sleep, !enable);
    end
    if (fault_n !== !(m_fault && rst_n)) begin
      fails++;
      $display("FAIL %s fault_n: %b expected %b", tag, fault_n, !(m_fault && rst_n));
    end
  endtask

  // apply inputs just after a falling edge, check 1 ns later, wait for next falling edge
  task automatic step(string tag, logic a, logic b, logic d, logic e, logic sc, logic ht);
    in1 = a; in2 = b; dis_hi = d; enable = e; short_evt = sc; hot_evt = ht;
    #1 check(tag);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R1", 0, 0, 0, 1, 0, 0);
    step("R1", 1, 1, 0, 1, 0, 0);
    rst_n = 1'b1;
    step("R1", 1, 1, 0, 1, 0, 0);
    // R2 independent legs
    step("R2", 1, 0, 0, 1, 0, 0);
    step("R2", 1, 0, 0, 1, 0, 0);
    step("R2", 0, 1, 0, 1, 0, 0);
    // R4 dead time on both legs
    step("R4", 0, 1, 0, 1, 0, 0);
    step("R4", 1, 0, 0, 1, 0, 0);
    step("R4", 1, 0, 0, 1, 0, 0);
    step("R4", 1, 0, 0, 1, 0, 0);
    // R5 active-high disable, faults still latch underneath
    step("R5", 1, 0, 1, 1, 0, 0);
    step("R5", 1, 0, 1, 1, 0, 0);
    step("R5", 1, 0, 1, 1, 1, 0);
    step("R5", 1, 0, 1, 1, 0, 0);
    step("R10", 1, 0, 0, 1, 0, 0);
    step("R10", 1, 0, 0, 1, 0, 0);
    step("R10", 1, 0, 0, 1, 0, 0);
    // R6 enable low blocks without a clock edge; R7 sleep
    in1 = 1; in2 = 1; enable = 0;
    #0.5 check("R6");
    #0.5;
    @(negedge clk);
    step("R6", 1, 1, 0, 0, 0, 0);
    step("R7", 1, 1, 0, 1, 0, 0);
    step("R7", 1, 1, 0, 1, 0, 0);
    // R8 short latch, cleared by enable toggle
    step("R8", 1, 1, 0, 1, 1, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 1, 0, 0);
    step("R10", 0, 0, 0, 1, 0, 0);
    // R9 over-temperature latch, clear attempt with a fault present relatches
    step("R9", 1, 0, 0, 1, 0, 1);
    step("R9", 1, 0, 1, 1, 0, 0);
    step("R10", 1, 0, 0, 1, 0, 1);
    step("R10", 1, 0, 0, 1, 0, 0);
    step("R10", 1, 0, 1, 1, 0, 0);
    step("R10", 1, 0, 0, 1, 0, 0);
    step("R10", 1, 0, 0, 1, 0, 0);
    // randomized mix
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      step("R2/R4/R8", 1'($urandom), 1'($urandom), r < 4, r < 96 || r > 98,
           $urandom_range(0, 60) == 0, $urandom_range(0, 80) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule